// File: doc/BRIEF.md
# Beam Position Sequencer

This block holds a table of beam-weight sets and applies them one after another to a bank of phase and amplitude stages. Each stored position carries a transmit set and a receive set. Each set holds a phase word and an amplitude word for every channel. A host write port fills the table, sets two bounding pointers and can write a staging register directly. A one-cycle advance pulse starts a fixed-length fetch of the next position into a staging rank. A separate load pulse then copies the staging rank into the active rank that drives the outputs. The transmit/receive input selects which of the two active sets appears at the outputs.

The two pointers mark a first and a last position, and the sequence wraps from the last back to the first. The sequencer settles its next step when a position is fetched, not when it is left. Because of this, a host can rewrite the pointers and the positions outside the running region while the region is in use. This allows ping-pong use of the table. In direct-register mode the sequencer stays idle, and the host applies one beam by writing the staging rank and issuing a load.

Top module: `beam_seq_top`

## Requirements
- R1: After reset, `pos_idx` is 0, `busy` and `overrun` are 0, all phase and amplitude outputs are 0, the first pointer is 0 and the last pointer is NPOS-1.
- R2: An accepted advance pulse raises `busy` on the next cycle and holds it for exactly FETCH (6) cycles. `pos_idx` changes only in the cycle in which `busy` falls.
- R3: The first accepted advance after reset fetches the position held in the first pointer. Every later advance fetches the successor chosen when the current position was fetched, which is normally the current index plus one.
- R4: The successor of the last-pointer position is the first-pointer position. The successor of position NPOS-1, when it is not the last pointer, is position 0.
- R5: The successor of a position is computed from the pointer values present when that position's fetch completes. A pointer written while position P is current changes the step out of P+1 and later steps, but not the step out of P.
- R6: Fetched data and host staging writes do not change the outputs until a load pulse. A load copies both the transmit and the receive staged sets to the active rank, and the outputs show them one cycle later.
- R7: A load pulse while `busy` is high has no effect on the active rank.
- R8: With `tr_mode`=1 the outputs show the active transmit set, and with `tr_mode`=0 the active receive set. Channel c drives `phase_out[c*7 +: 7]` and `amp_out[c*7 +: 7]`.
- R9: An advance pulse while `busy` is high is ignored: it changes neither the fetch length nor the target. It raises `overrun` for one cycle, on the next cycle.
- R10: With `reg_mode`=1, an advance pulse does not start a fetch and `pos_idx` holds. Host staging writes followed by a load reach the outputs.
- R11: Host write encoding: `wr_kind` 0 writes a table word, 1 the first pointer, 2 the last pointer, 3 the staging rank. `wr_dir`=1 selects the transmit set. `wr_data` is {phase[13:7], amp[6:0]} for channel `wr_ch`. Pointer values and table positions come from `wr_pos`. A table or pointer write with `wr_pos` >= NPOS is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_kind | input | 2 | Write target: 0 table, 1 first pointer, 2 last pointer, 3 staging |
| wr_pos | input | 7 | Table position or pointer value |
| wr_dir | input | 1 | 1 transmit set, 0 receive set |
| wr_ch | input | 2 | Channel index |
| wr_data | input | 14 | {phase, amplitude} word |
| reg_mode | input | 1 | 1 selects direct-register mode |
| adv | input | 1 | Beam-advance pulse |
| load | input | 1 | Load pulse, staging to active rank |
| tr_mode | input | 1 | 1 transmit, 0 receive output set |
| phase_out | output | 28 | Active phase words, 7 bits per channel |
| amp_out | output | 28 | Active amplitude words, 7 bits per channel |
| pos_idx | output | 7 | Index of the last fetched position |
| busy | output | 1 | Fetch in progress |
| overrun | output | 1 | One-cycle flag for an advance rejected during a fetch |

## Verification
The assertions assume that `adv` and `load` are single-cycle pulses. They also assume that `tr_mode` is held steady whenever output stability is claimed, and that host staging writes never coincide with the last fetch cycle. The stimulus drives every pulse for exactly one cycle and issues host writes only between fetches. It changes `tr_mode` only while it reads the outputs. It confines its deliberate collisions, an advance or a load inside a fetch window, to the second fetch cycle.

// File: rtl/beam_seq_pkg.sv
package beam_seq_pkg;

  localparam logic [1:0] WK_TABLE = 2'd0;
  localparam logic [1:0] WK_FIRST = 2'd1;
  localparam logic [1:0] WK_LAST  = 2'd2;
  localparam logic [1:0] WK_STAGE = 2'd3;

  // Successor of a position inside a wrapping region bounded by first/last.
  function automatic int seq_step(input int cur, input int first,
                                  input int last, input int npos);
    if (cur == last)        return first;
    else if (cur + 1 >= npos) return 0;
    else                    return cur + 1;
  endfunction

endpackage

// File: rtl/beam_pos_mem.sv
module beam_pos_mem #(
  parameter int NPOS = 121,
  parameter int NCH  = 4,
  parameter int WW   = 7,
  localparam int PW   = $clog2(NPOS),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW   = 2 * WW,
  localparam int WORD = NCH * DW
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PW-1:0]   wpos,
  input  logic            wdir,
  input  logic [CHW-1:0]  wch,
  input  logic [DW-1:0]   wdata,
  input  logic [PW-1:0]   rpos,
  output logic [WORD-1:0] rd_tx,
  output logic [WORD-1:0] rd_rx
);

  logic [WORD-1:0] store [2*NPOS];
  logic [PW:0]     waddr;

  assign waddr = {wpos, wdir};

  always_ff @(posedge clk) begin
    if (we) store[waddr][int'(wch)*DW +: DW] <= wdata;
  end

  assign rd_tx = store[{rpos, 1'b1}];
  assign rd_rx = store[{rpos, 1'b0}];

endmodule

// File: rtl/beam_ptr_seq.sv
module beam_ptr_seq
  import beam_seq_pkg::*;
#(
  parameter int NPOS  = 121,
  parameter int FETCH = 6,
  localparam int PW = $clog2(NPOS),
  localparam int CW = $clog2(FETCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          reg_mode_i,
  input  logic          first_we,
  input  logic          last_we,
  input  logic [PW-1:0] ptr_val,
  output logic          busy_o,
  output logic          fetch_done_o,
  output logic          adv_take_o,
  output logic [PW-1:0] tgt_o,
  output logic [PW-1:0] pos_o,
  output logic          overrun_o
);

  logic [PW-1:0] first_q, last_q, nxt_q, tgt_q, pos_q;
  logic [CW-1:0] cnt_q;
  logic          primed_q, busy_q, ovr_q;

  assign adv_take_o   = adv_i && !busy_q && !reg_mode_i;
  assign fetch_done_o = busy_q && (cnt_q == CW'(FETCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      last_q   <= PW'(NPOS - 1);
      nxt_q    <= '0;
      tgt_q    <= '0;
      pos_q    <= '0;
      cnt_q    <= '0;
      primed_q <= 1'b0;
      busy_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      ovr_q <= adv_i && busy_q;
      if (first_we) first_q <= ptr_val;
      if (last_we)  last_q  <= ptr_val;
      if (adv_take_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        tgt_q  <= primed_q ? nxt_q : first_q;
      end else if (fetch_done_o) begin
        busy_q   <= 1'b0;
        pos_q    <= tgt_q;
        primed_q <= 1'b1;
        nxt_q    <= PW'(seq_step(int'(tgt_q), int'(first_q), int'(last_q), NPOS));
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o    = busy_q;
  assign tgt_o     = tgt_q;
  assign pos_o     = pos_q;
  assign overrun_o = ovr_q;

endmodule

// File: rtl/beam_out_regs.sv
module beam_out_regs #(
  parameter int NCH = 4,
  parameter int WW  = 7,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW   = 2 * WW,
  localparam int WORD = NCH * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_done,
  input  logic [WORD-1:0] f_tx,
  input  logic [WORD-1:0] f_rx,
  input  logic            st_we,
  input  logic            st_dir,
  input  logic [CHW-1:0]  st_ch,
  input  logic [DW-1:0]   st_data,
  input  logic            load_take,
  output logic [WORD-1:0] act_tx,
  output logic [WORD-1:0] act_rx
);

  logic [WORD-1:0] stg_tx, stg_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_tx <= '0;
      stg_rx <= '0;
      act_tx <= '0;
      act_rx <= '0;
    end else begin
      if (fetch_done) begin
        stg_tx <= f_tx;
        stg_rx <= f_rx;
      end else if (st_we) begin
        if (st_dir) stg_tx[int'(st_ch)*DW +: DW] <= st_data;
        else        stg_rx[int'(st_ch)*DW +: DW] <= st_data;
      end
      if (load_take) begin
        act_tx <= stg_tx;
        act_rx <= stg_rx;
      end
    end
  end

endmodule

// File: rtl/beam_seq_top.sv
module beam_seq_top
  import beam_seq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int WW    = 7,
  parameter int NPOS  = 121,
  parameter int FETCH = 6,
  localparam int PW   = $clog2(NPOS),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW   = 2 * WW,
  localparam int WORD = NCH * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [PW-1:0]     wr_pos,
  input  logic              wr_dir,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [DW-1:0]     wr_data,
  input  logic              reg_mode,
  input  logic              adv,
  input  logic              load,
  input  logic              tr_mode,
  output logic [NCH*WW-1:0] phase_out,
  output logic [NCH*WW-1:0] amp_out,
  output logic [PW-1:0]     pos_idx,
  output logic              busy,
  output logic              overrun
);

  logic            pos_ok, tbl_we, first_we, last_we, stage_we;
  logic            fetch_done, adv_take, load_take;
  logic [PW-1:0]   tgt;
  logic [WORD-1:0] rd_tx, rd_rx, act_tx, act_rx, act_sel;

  assign pos_ok    = int'(wr_pos) < NPOS;
  assign tbl_we    = wr_en && pos_ok && (wr_kind == WK_TABLE);
  assign first_we  = wr_en && pos_ok && (wr_kind == WK_FIRST);
  assign last_we   = wr_en && pos_ok && (wr_kind == WK_LAST);
  assign stage_we  = wr_en && (wr_kind == WK_STAGE);
  assign load_take = load && !busy;

  beam_pos_mem #(.NPOS(NPOS), .NCH(NCH), .WW(WW)) u_mem (
    .clk(clk), .we(tbl_we), .wpos(wr_pos), .wdir(wr_dir), .wch(wr_ch),
    .wdata(wr_data), .rpos(tgt), .rd_tx(rd_tx), .rd_rx(rd_rx)
  );

  beam_ptr_seq #(.NPOS(NPOS), .FETCH(FETCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .reg_mode_i(reg_mode),
    .first_we(first_we), .last_we(last_we), .ptr_val(wr_pos),
    .busy_o(busy), .fetch_done_o(fetch_done), .adv_take_o(adv_take),
    .tgt_o(tgt), .pos_o(pos_idx), .overrun_o(overrun)
  );

  beam_out_regs #(.NCH(NCH), .WW(WW)) u_out (
    .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .f_tx(rd_tx),
    .f_rx(rd_rx), .st_we(stage_we), .st_dir(wr_dir), .st_ch(wr_ch),
    .st_data(wr_data), .load_take(load_take), .act_tx(act_tx), .act_rx(act_rx)
  );

  assign act_sel = tr_mode ? act_tx : act_rx;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign phase_out[c*WW +: WW] = act_sel[c*DW + WW +: WW];
    assign amp_out[c*WW +: WW]   = act_sel[c*DW +: WW];
  end

endmodule

// File: rtl/beam_seq_chk.sv
module beam_seq_chk #(
  parameter int NCH   = 4,
  parameter int WW    = 7,
  parameter int NPOS  = 121,
  parameter int FETCH = 6,
  localparam int PW = $clog2(NPOS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              load,
  input logic              reg_mode,
  input logic              tr_mode,
  input logic              busy,
  input logic              overrun,
  input logic              adv_take,
  input logic [PW-1:0]     pos_idx,
  input logic [NCH*WW-1:0] phase_out,
  input logic [NCH*WW-1:0] amp_out
);

  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= FETCH); // R2
  AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == FETCH); // R2
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(pos_idx)); // R2
  AST_ADV_START: assert property (@(posedge clk) disable iff (!rst_n)
    adv_take |=> busy); // R2
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_idx) < NPOS); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !$stable(tr_mode) == 1'b0) |=> (($stable(phase_out) && $stable(amp_out)) || !$stable(tr_mode))); // R6
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |=> (($stable(phase_out) && $stable(amp_out)) || !$stable(tr_mode))); // R7
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && busy) |=> overrun); // R9
  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(adv && busy)); // R9
  AST_REG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_mode && !busy) |=> !busy); // R10

endmodule

bind beam_seq_top beam_seq_chk #(.NCH(NCH), .WW(WW), .NPOS(NPOS), .FETCH(FETCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .load(load), .reg_mode(reg_mode),
  .tr_mode(tr_mode), .busy(busy), .overrun(overrun), .adv_take(adv_take),
  .pos_idx(pos_idx), .phase_out(phase_out), .amp_out(amp_out)
);

// File: tb/sim_beam_seq_top.sv
module sim_beam_seq_top;
  localparam int NCH = 4, WW = 7, NPOS = 121, FETCH = 6;
  localparam int PW = 7, CHW = 2, DW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_dir = 0, reg_mode = 0, adv = 0, load = 0, tr_mode = 0;
  logic [1:0] wr_kind = 0;
  logic [PW-1:0] wr_pos = 0;
  logic [CHW-1:0] wr_ch = 0;
  logic [DW-1:0] wr_data = 0;
  logic [NCH*WW-1:0] phase_out, amp_out;
  logic [PW-1:0] pos_idx;
  logic busy, overrun;

  beam_seq_top u0 (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] m_mem [NPOS][2][NCH];
  logic [DW-1:0] m_stg [2][NCH];
  logic [DW-1:0] m_act [2][NCH];
  int m_first, m_last, m_pos, m_next;
  bit m_primed;

  function automatic int nstep(int p, int f, int l);
    if (p == l) return f;
    if (p + 1 >= NPOS) return 0;
    return p + 1;
  endfunction

  function automatic logic [NCH*WW-1:0] exp_field(int d, bit ph);
    logic [NCH*WW-1:0] v;
    for (int c = 0; c < NCH; c++)
      v[c*WW +: WW] = ph ? m_act[d][c][DW-1:WW] : m_act[d][c][WW-1:0];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] a, input logic [63:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
    end
  endtask

  task automatic chk_out(input string req);
    for (int d = 0; d < 2; d++) begin
      tr_mode = d[0];
      #1;
      chk(phase_out == exp_field(d, 1), {req, " R8"}, "phase_out", 64'(phase_out), 64'(exp_field(d, 1)));
      chk(amp_out == exp_field(d, 0), {req, " R8"}, "amp_out", 64'(amp_out), 64'(exp_field(d, 0)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; adv = 0; load = 0; reg_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_first = 0; m_last = NPOS - 1; m_pos = 0; m_next = 0; m_primed = 0;
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < NCH; c++) begin m_stg[d][c] = '0; m_act[d][c] = '0; end
    @(negedge clk);
    chk(pos_idx == 0, "R1", "pos_idx", 64'(pos_idx), 0);
    chk(busy == 0, "R1", "busy", 64'(busy), 0);
    chk(overrun == 0, "R1", "overrun", 64'(overrun), 0);
    chk_out("R1");
  endtask

  task automatic hw(input int kind, input int pos, input int dir, input int ch, input int data);
    @(negedge clk);
    wr_en = 1; wr_kind = 2'(kind); wr_pos = PW'(pos); wr_dir = dir[0];
    wr_ch = CHW'(ch); wr_data = DW'(data);
    @(negedge clk);
    wr_en = 0;
    if (kind == 0 && pos < NPOS) m_mem[pos][dir][ch] = DW'(data);
    if (kind == 1 && pos < NPOS) m_first = pos;
    if (kind == 2 && pos < NPOS) m_last = pos;
    if (kind == 3) m_stg[dir][ch] = DW'(data);
  endtask

  // Full fetch; optional advance and/or load in the second fetch cycle.
  task automatic adv_with(input bit x_adv, input bit x_load, input string tag);
    int tgt;
    tgt = m_primed ? m_next : m_first;
    @(negedge clk); adv = 1;
    @(negedge clk); adv = 0;
    chk(busy == 1, "R2", "busy rise", 64'(busy), 1);
    @(negedge clk); adv = x_adv; load = x_load;
    @(negedge clk); adv = 0; load = 0;
    chk(overrun == x_adv, "R9", "overrun", 64'(overrun), 64'(x_adv));
    chk_out("R7");
    repeat (3) @(negedge clk);
    chk(busy == 1, "R2", "busy last cycle", 64'(busy), 1);
    chk(pos_idx == PW'(m_pos), "R2", "pos before end", 64'(pos_idx), 64'(m_pos));
    @(negedge clk);
    chk(busy == 0, "R2", "busy fall", 64'(busy), 0);
    chk(pos_idx == PW'(tgt), tag, "pos_idx", 64'(pos_idx), 64'(tgt));
    m_pos = tgt; m_primed = 1; m_next = nstep(tgt, m_first, m_last);
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < NCH; c++) m_stg[d][c] = m_mem[tgt][d][c];
  endtask

  task automatic do_load(input string tag);
    @(negedge clk); load = 1;
    @(negedge clk); load = 0;
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < NCH; c++) m_act[d][c] = m_stg[d][c];
    chk_out(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    for (int p = 0; p < NPOS; p++)
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < NCH; c++) hw(0, p, d, c, int'($urandom % 16384));

    // R6: fetch does not reach outputs before load
    adv_with(0, 0, "R3 first");
    chk_out("R6 pre-load");
    do_load("R6");
    adv_with(0, 0, "R3 step");

    // R5: pointer lead rule
    hw(1, 5, 0, 0, 0);
    hw(2, 8, 0, 0, 0);
    while (m_pos != 7) adv_with(0, 0, "R3 walk");
    hw(2, 7, 0, 0, 0);
    adv_with(0, 0, "R5 old decision");
    adv_with(0, 0, "R5 new pointer");
    hw(2, 10, 0, 0, 0);
    adv_with(0, 0, "R5 to last");
    adv_with(0, 0, "R4 wrap to first");

    // R9 and R7
    adv_with(1, 0, "R9 ignored advance");
    adv_with(0, 1, "R7 target");
    chk_out("R7 after fetch");
    do_load("R6 second");

    // R10 direct-register mode
    @(negedge clk); reg_mode = 1;
    @(negedge clk); adv = 1;
    @(negedge clk); adv = 0;
    chk(busy == 0, "R10", "busy", 64'(busy), 0);
    @(negedge clk);
    chk(pos_idx == PW'(m_pos), "R10", "pos hold", 64'(pos_idx), 64'(m_pos));
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < NCH; c++) hw(3, 0, d, c, int'($urandom % 16384));
    chk_out("R6 staged");
    do_load("R10");
    @(negedge clk); reg_mode = 0;

    // R11 out-of-range pointer writes are ignored
    hw(1, 126, 0, 0, 0);
    hw(2, 123, 0, 0, 0);
    for (int i = 0; i < 6; i++) adv_with(0, 0, "R11");

    // R4 wrap past the end of the table
    do_reset();
    hw(1, 119, 0, 0, 0);
    hw(2, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) adv_with(0, 0, "R4 end wrap");
    do_load("R6 end wrap");

    // Random phase
    hw(1, 3, 0, 0, 0);
    hw(2, 9, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 6)
        0: hw(0, int'($urandom % 128), int'($urandom % 2), int'($urandom % NCH), int'($urandom % 16384));
        1: hw(3, 0, int'($urandom % 2), int'($urandom % NCH), int'($urandom % 16384));
        2: adv_with(($urandom % 4) == 0, ($urandom % 4) == 0, "R3 random");
        3: do_load("R6 random");
        4: hw(1 + int'($urandom % 2), int'($urandom % 128), 0, 0, 0);
        default: chk_out("R8 random");
      endcase
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule